// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus of Ethernet PHYs (IEEE 802.3 clause 22) from a single 32-bit access register. Software writes one word holding a start flag, a direction flag, a PHY address, a register address and, for writes, sixteen data bits. The block then clocks a complete management frame out on MDC/MDIO. For reads it captures the PHY's answer into the low half of the same register.

Completion is signalled through the start flag itself. It reads back as 1 while the frame is on the wire and drops to 0 when the frame has finished, so software polls one register both for status and for read data. A separate divider setting fixes the MDC period in system-clock cycles. The access register and the divider setting both refuse writes while a frame is in flight.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the access register reads 0, MDC is low and the MDIO output enable is low.
- R2: A write to the access register with bit 31 set starts a frame. Bit 31 then reads 1 until the frame ends and 0 afterwards. The field layout is: bit 30 = 1 for a write and 0 for a read, bits 25:21 = PHY address, bits 20:16 = register address, bits 15:0 = data.
- R3: A write frame, sampled on each MDC rising edge, is 32 ones, then 01, then opcode 01, the PHY address, the register address, turnaround 10, and the 16 data bits. All fields are sent most significant bit first.
- R4: A read frame uses opcode 10. The output enable is high for the first 46 bits and low from the first turnaround bit to the end. The 16 bits sampled at MDC rising edges after the turnaround appear in bits 15:0 of the access register, and bits 30:16 keep their written values.
- R5: With divider setting D, MDC stays low and high for D+1 system clocks each. MDC is low whenever no frame is running, and MDIO only changes together with a falling edge of MDC.
- R6: Writes to the access register or to the divider setting while a frame is running are ignored. The running frame's length and result are unaffected.
- R7: A write to the access register with bit 31 clear stores the word, which reads back unchanged, and produces no MDC edges.
- R8: A frame holds bit 31 at 1 for exactly 128*(D+1) system clock cycles and produces exactly 64 MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe for the access register |
| acc_wdata | input | 32 | Access register write data |
| acc_rdata | output | 32 | Access register read value, bit 31 is busy |
| div_wr | input | 1 | Write strobe for the MDC divider setting |
| div_wdata | input | DIV_W | New divider setting D (half period D+1 clocks) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | MDIO level seen at the pad |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A behavioural PHY on the bench answers reads and records every bit on the MDC rising edge. Each frame is compared bit for bit, together with the output-enable pattern. A design that sent the wrong opcode or turnaround, or kept driving through the turnaround, would show up in that comparison. The divider value 0 is covered as the fastest case, and frame length is measured in clocks, which exposes an off-by-one in the divider or an extra or missing bit. Further tests inject writes in the middle of a frame, where a design that accepted them would shorten the frame or corrupt its result. A request written without the start bit is also checked, and must stay silent on the bus.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int          FRAME_BITS = 64;
  localparam logic [6:0]  LAST_IDX   = 7'd63;
  localparam logic [6:0]  TA_IDX     = 7'd46;
  localparam logic [6:0]  DATA_IDX   = 7'd48;

  typedef struct packed {
    logic        req;
    logic        wr;
    logic [3:0]  spare;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } acc_word_t;

  // Full management frame, first bit to go out in bit 63.
  function automatic logic [63:0] build_frame(logic wr, logic [4:0] phy,
                                              logic [4:0] regad, logic [15:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = wr ? 2'b01 : 2'b10;
    ta = wr ? 2'b10 : 2'b11;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, (wr ? d : 16'hFFFF)};
  endfunction

  // Master owns the line for this bit position?
  function automatic logic owns_bit(logic wr, logic [6:0] idx);
    return wr || (idx < TA_IDX);
  endfunction

  // Bit position carries read data from the PHY?
  function automatic logic takes_bit(logic wr, logic [6:0] idx);
    return !wr && (idx >= DATA_IDX);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick      = en && (cnt == div);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == div) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: clock parked low when no frame runs
  p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mdc);
  // R5: phase counter never passes the divider setting
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= div);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        mdc,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_in,
  output logic        busy,
  output logic        done,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  logic [63:0] frame;
  logic [6:0]  idx;
  logic        is_wr;

  assign done     = busy && fall_tick && (idx == LAST_IDX);
  assign mdio_out = busy ? frame[63] : 1'b1;
  assign mdio_oe  = busy && owns_bit(is_wr, idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame   <= '1;
      idx     <= '0;
      is_wr   <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        frame <= build_frame(wr, phy, regad, wdata);
        idx   <= '0;
        is_wr <= wr;
        busy  <= 1'b1;
      end
    end else begin
      if (rise_tick && takes_bit(is_wr, idx))
        rd_data <= {rd_data[14:0], mdio_in};
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 7'd1;
          frame <= {frame[62:0], 1'b1};
        end
      end
    end
  end

  // R5: line changes only together with a falling MDC edge
  p_mdio_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mdio_out) |-> $fell(mdc));
  // R8: one bit position per MDC period
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fall_tick && idx != LAST_IDX |=> idx == $past(idx) + 7'd1);
  // R4: no capture while the master itself drives the line
  p_no_capture_driving_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rise_tick && mdio_oe |=> $stable(rd_data));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             mdc,
  input  logic             mdio_in,
  output logic             mdio_out,
  output logic             mdio_oe
);
  import mdio_mgmt_pkg::*;

  acc_word_t        wword;
  logic [30:0]      acc_q;
  logic [DIV_W-1:0] div_q;
  logic             busy, done, accept, start;
  logic             rise_tick, fall_tick;
  logic [15:0]      rd_data;

  assign wword     = acc_word_t'(acc_wdata);
  assign accept    = acc_wr && !busy;
  assign start     = accept && wword.req;
  assign acc_rdata = {busy, acc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      div_q <= DIV_RESET;
    end else begin
      if (accept)
        acc_q <= acc_wdata[30:0];
      else if (done && !acc_q[30])
        acc_q[15:0] <= rd_data;
      if (div_wr && !busy)
        div_q <= div_wdata;
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr        (wword.wr),
    .phy       (wword.phy),
    .regad     (wword.regad),
    .wdata     (wword.data),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_in   (mdio_in),
    .busy      (busy),
    .done      (done),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data)
  );

  // R6: request fields frozen while a frame runs
  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(acc_q[30:16]));
  // R6: divider frozen while a frame runs
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(div_q));
  // R2: end of frame drops the request flag
  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !acc_rdata[31]);
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        div_wr = 1'b0;
  logic [7:0]  div_wdata = '0;
  logic        mdc, mdio_out, mdio_oe;
  logic        phy_drive = 1'b1;
  wire         mdio_bus = mdio_oe ? mdio_out : phy_drive;

  int checks = 0, failures = 0, cycles = 0, edge_cnt = 0;
  logic [63:0] cap_bits = '0, oe_bits = '0;
  logic        rd_frame = 1'b0;
  logic [15:0] phy_val = '0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.DIV_W(8), .DIV_RESET(8'd4)) uut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .div_wr(div_wr), .div_wdata(div_wdata),
    .mdc(mdc), .mdio_in(phy_drive), .mdio_out(mdio_out), .mdio_oe(mdio_oe));

  // Behavioural PHY: records bus and enable at MDC rise, answers reads after MDC fall
  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], mdio_bus};
    oe_bits  = {oe_bits[62:0], mdio_oe};
    edge_cnt = edge_cnt + 1;
  end
  always @(negedge mdc) begin
    if (rd_frame && edge_cnt == 47)                      phy_drive = 1'b0;
    else if (rd_frame && edge_cnt >= 48 && edge_cnt <= 63) phy_drive = phy_val[63 - edge_cnt];
    else                                                 phy_drive = 1'b1;
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [7:0] d);
    @(negedge clk); div_wr = 1'b1; div_wdata = d;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [15:0] pv);
    edge_cnt = 0; cap_bits = '0; oe_bits = '0;
    rd_frame = !w[30]; phy_val = pv;
    acc_wr = 1'b1; acc_wdata = w;
    @(negedge clk); acc_wr = 1'b0;
  endtask

  task automatic wait_idle(input int start_n, output int n);
    n = start_n;
    while (acc_rdata[31] && n < 100000) begin
      @(negedge clk); n = n + 1;
    end
  endtask

  function automatic logic [63:0] exp_frame(logic [31:0] w, logic [15:0] pv);
    if (w[30]) return {32'hFFFF_FFFF, 2'b01, 2'b01, w[25:21], w[20:16], 2'b10, w[15:0]};
    return {32'hFFFF_FFFF, 2'b01, 2'b10, w[25:21], w[20:16], 2'b10, pv};
  endfunction

  // {access word, divider, PHY answer}
  localparam logic [55:0] VEC [6] = '{
    {32'hC0A0_9000, 8'd2, 16'h0000},
    {32'hC0C0_9000, 8'd0, 16'h0000},
    {32'h80C1_0000, 8'd1, 16'h782D},
    {32'h83FF_1234, 8'd3, 16'hA5C3},
    {32'hC000_FFFF, 8'd5, 16'h0000},
    {32'h8000_0000, 8'd0, 16'h0001}
  };

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 access reg after reset", 64'(acc_rdata), 64'h0);
    chk("R1 mdc after reset", 64'(mdc), 64'h0);
    chk("R1 oe after reset", 64'(mdio_oe), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] w;
      logic [7:0]  d;
      logic [15:0] pv;
      {w, d, pv} = VEC[i];
      set_div(d);
      issue(w, pv);
      chk("R2 busy after start", 64'(acc_rdata[31]), 64'h1);
      wait_idle(0, n);
      chk("R8/R5 frame length", 64'(n), 64'(128 * (int'(d) + 1)));
      chk("R8 mdc rising edges", 64'(edge_cnt), 64'd64);
      chk(w[30] ? "R3 write frame bits" : "R4 read frame bits", cap_bits, exp_frame(w, pv));
      chk("R4 output enable pattern", oe_bits,
          w[30] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000);
      chk(w[30] ? "R2 readback after write" : "R4 read data in register",
          64'(acc_rdata), w[30] ? 64'({1'b0, w[30:0]}) : 64'({1'b0, w[30:16], pv}));
      chk("R5 mdc low when idle", 64'(mdc), 64'h0);
    end

    // R6: writes in the middle of a read frame are ignored
    set_div(8'd2);
    issue(32'h80A2_0000, 16'h5A3C);
    repeat (50) @(negedge clk);
    acc_wr = 1'b1; acc_wdata = 32'hC0C1_AAAA;
    div_wr = 1'b1; div_wdata = 8'd7;
    @(negedge clk); acc_wr = 1'b0; div_wr = 1'b0;
    wait_idle(51, n);
    chk("R6 length unaffected by mid-frame writes", 64'(n), 64'd384);
    chk("R6 result unaffected by mid-frame writes", 64'(acc_rdata), 64'h00A2_5A3C);
    chk("R6 frame unaffected", cap_bits, exp_frame(32'h80A2_0000, 16'h5A3C));
    // divider must still be 2: next frame length
    issue(32'hC020_0001, 16'h0);
    wait_idle(0, n);
    chk("R6 divider write ignored while busy", 64'(n), 64'd384);

    // R7: no start bit, stored only
    issue(32'h00A0_9000, 16'h0);
    repeat (40) @(negedge clk);
    chk("R7 word stored", 64'(acc_rdata), 64'h00A0_9000);
    chk("R7 no mdc edges", 64'(edge_cnt), 64'd0);
    chk("R7 mdc low", 64'(mdc), 64'd0);

    summary();
  end
endmodule